// File: doc/BRIEF.md
# Symmetric Two-Phase Fast FIR Filter

This block is an N-tap FIR filter that takes two input samples per clock and produces two output samples per clock. Its coefficient set has even length and is even-symmetric (tap i equals tap N-1-i). The coefficients are split into even-index and odd-index phases. Because the set is mirror-symmetric, the odd phase is the even phase reversed. The block therefore computes with three sub-filters: the phase sum, which is symmetric; the phase difference, which is antisymmetric; and the odd phase on its own.

The two symmetric-type sub-filters fold their delay lines. Two taps that share a coefficient magnitude are added (in the sum filter) or subtracted (in the difference filter) before the one multiplier they share. The whole filter thus needs N multipliers, where a plain two-phase fast filter needs 3N/2. A post-processing stage halves the sum and difference results with an exact arithmetic shift and adds the odd-phase term delayed by one block. The results match the direct-form convolution bit for bit.

In use, the older sample of each pair goes on `x0` and the newer on `x1`, both qualified by `in_valid`. Each valid pair produces one result pair on `y0` and `y1` two clocks later. The coefficient set, sample width and coefficient width are parameters. An odd tap count, a count below four, a non-symmetric set or a too-narrow output width stops elaboration.

Top module: `fsf_sym2_fir`

## Requirements
- R1: For the k-th accepted input pair after reset, `y0` equals the full-precision convolution output y[2k] = sum over i of h[i]*x[2k-i]. Here x[2j] is the `x0` of pair j, x[2j+1] is the `x1` of pair j, and samples before reset count as zero.
- R2: For the same k-th pair, `y1` equals y[2k+1] = sum over i of h[i]*x[2k+1-i], computed the same way.
- R3: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` was sampled high. It is low otherwise, and no result pair appears without a matching input pair.
- R4: Values on `x0` and `x1` in cycles where `in_valid` is low have no effect on any later result, and such cycles do not advance the filter history.
- R5: `y0` and `y1` keep their previous values in every cycle in which `out_valid` is low.
- R6: While `rst_n` is low, `out_valid`, `y0` and `y1` are zero. After reset is released, all earlier samples are forgotten, so results depend only on pairs accepted since then.
- R7: Results are exact two's complement values of width OW (default DW+CW+ceil(log2 N)), with no rounding, truncation of fractional bits or wrap. This holds even for full-scale inputs (+32767 and -32768 at DW=16) in any sign pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the input pair in this cycle |
| x0 | input | DW | Older sample of the pair, signed |
| x1 | input | DW | Newer sample of the pair, signed |
| out_valid | output | 1 | Qualifies the result pair |
| y0 | output | OW | Even-phase output sample, signed |
| y1 | output | OW | Odd-phase output sample, signed |

## Verification
A unit impulse on `x0` and then on `x1` shows whether each coefficient ends up in the correct output phase. It also shows whether the one-block delay of the odd-phase term and the sign of the difference filter are right, since a swapped fold or a missing delay moves or negates single taps. Random pairs exercise the recombination in general. Full-scale runs of maximum, minimum and alternating extremes show any lost bit in the halving shift or any wrap in the wide accumulators. Random idle gaps with garbage data, together with a reset in the middle of a run, distinguish history that advances only on valid pairs and is fully cleared from history that leaks.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

   // Folding flavour of a mirror-structured sub-filter
   typedef enum logic [0:0] {
      FOLD_SUM  = 1'b0,   // coefficients mirror equal: pre-add
      FOLD_DIFF = 1'b1    // coefficients mirror negated: pre-subtract
   } fold_e;

   // Number of multipliers a folded branch needs
   function automatic int fold_mults(input int m, input fold_e mode);
      return (m / 2) + (((m % 2) == 1 && mode == FOLD_SUM) ? 1 : 0);
   endfunction

endpackage

// File: rtl/fsf_fold_branch.sv
module fsf_fold_branch
   import fsf_pkg::*;
#(
   parameter int              M    = 5,
   parameter int              IW   = 17,
   parameter int              KW   = 13,
   parameter int              AW   = 36,
   parameter fold_e           MODE = FOLD_SUM,
   parameter logic [M*KW-1:0] KVEC = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [IW-1:0] din,
   output logic signed [AW-1:0] acc
);

   localparam int NPAIR = M / 2;
   localparam int NPROD = fold_mults(M, MODE);
   localparam int PW    = IW + 1;

   if (M < 2) begin : g_len_bad
      $error("fsf_fold_branch: M must be at least 2");
   end

   logic signed [IW-1:0] line_q [M-1];
   logic signed [IW-1:0] tap    [M];
   logic signed [AW-1:0] prod   [NPROD];
   logic signed [AW-1:0] total;

   assign tap[0] = din;
   for (genvar k = 1; k < M; k++) begin : g_tap
      assign tap[k] = line_q[k-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < M-1; k++) line_q[k] <= '0;
      end else if (en) begin
         line_q[0] <= din;
         for (int k = 1; k < M-1; k++) line_q[k] <= line_q[k-1];
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam logic signed [KW-1:0] KP = KVEC[p*KW +: KW];
      localparam logic signed [KW-1:0] KM = KVEC[(M-1-p)*KW +: KW];
      logic signed [PW-1:0] pre;
      if (MODE == FOLD_SUM) begin : g_sum
         if (KP != KM) begin : g_bad
            $error("fsf_fold_branch: sum branch coefficients not mirror equal");
         end
         assign pre = PW'(tap[p]) + PW'(tap[M-1-p]);
      end else begin : g_dif
         if ((int'(KP) + int'(KM)) != 0) begin : g_bad
            $error("fsf_fold_branch: difference branch coefficients not mirror negated");
         end
         assign pre = PW'(tap[p]) - PW'(tap[M-1-p]);
      end
      assign prod[p] = AW'(pre) * AW'(KP);
   end

   if ((M % 2) == 1) begin : g_odd_len
      localparam logic signed [KW-1:0] KC = KVEC[(M/2)*KW +: KW];
      if (MODE == FOLD_SUM) begin : g_mid
         assign prod[NPAIR] = AW'(tap[M/2]) * AW'(KC);
      end else begin : g_midz
         if (KC != '0) begin : g_bad
            $error("fsf_fold_branch: centre tap of difference branch must be zero");
         end
      end
   end

   always_comb begin
      total = '0;
      for (int p = 0; p < NPROD; p++) total = total + prod[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= total;
   end

endmodule

// File: rtl/fsf_plain_branch.sv
module fsf_plain_branch #(
   parameter int              M    = 5,
   parameter int              IW   = 16,
   parameter int              KW   = 13,
   parameter int              AW   = 36,
   parameter logic [M*KW-1:0] KVEC = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [IW-1:0] din,
   output logic signed [AW-1:0] acc
);

   if (M < 2) begin : g_len_bad
      $error("fsf_plain_branch: M must be at least 2");
   end

   logic signed [IW-1:0] line_q [M-1];
   logic signed [IW-1:0] tap    [M];
   logic signed [AW-1:0] prod   [M];
   logic signed [AW-1:0] total;

   assign tap[0] = din;
   for (genvar k = 1; k < M; k++) begin : g_tap
      assign tap[k] = line_q[k-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < M-1; k++) line_q[k] <= '0;
      end else if (en) begin
         line_q[0] <= din;
         for (int k = 1; k < M-1; k++) line_q[k] <= line_q[k-1];
      end
   end

   for (genvar k = 0; k < M; k++) begin : g_mul
      localparam logic signed [KW-1:0] KK = KVEC[k*KW +: KW];
      assign prod[k] = AW'(tap[k]) * AW'(KK);
   end

   always_comb begin
      total = '0;
      for (int k = 0; k < M; k++) total = total + prod[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= total;
   end

endmodule

// File: rtl/fsf_recombine.sv
module fsf_recombine #(
   parameter int AW = 36,
   parameter int OW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [AW-1:0] a_sum,
   input  logic signed [AW-1:0] b_dif,
   input  logic signed [AW-1:0] c_odd,
   output logic                 out_valid,
   output logic signed [OW-1:0] y0,
   output logic signed [OW-1:0] y1
);

   if (OW > AW) begin : g_w_bad
      $error("fsf_recombine: OW exceeds internal width");
   end

   logic signed [AW-1:0] c_prev;
   logic signed [AW-1:0] ab_plus, ab_minus;
   logic signed [AW-1:0] y0_w, y1_w;

   // Both brackets share parity, so the shift drops no information
   always_comb begin
      ab_plus  = a_sum + b_dif;
      ab_minus = a_sum - b_dif;
      y1_w     = ab_minus >>> 1;
      y0_w     = (ab_plus >>> 1) - c_odd + c_prev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y0        <= '0;
         y1        <= '0;
         c_prev    <= '0;
      end else begin
         out_valid <= en;
         if (en) begin
            y0     <= y0_w[OW-1:0];
            y1     <= y1_w[OW-1:0];
            c_prev <= c_odd;
         end
      end
   end

endmodule

// File: rtl/fsf_sym2_fir.sv
module fsf_sym2_fir
   import fsf_pkg::*;
#(
   parameter int                  DW       = 16,
   parameter int                  CW       = 12,
   parameter int                  NTAPS    = 10,
   parameter logic [NTAPS*CW-1:0] COEF_VEC = {12'h002, 12'hFF9, 12'hFED, 12'h036, 12'h0A1,
                                              12'h0A1, 12'h036, 12'hFED, 12'hFF9, 12'h002},
   parameter int                  OW       = DW + CW + $clog2(NTAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] x0,
   input  logic signed [DW-1:0] x1,
   output logic                 out_valid,
   output logic signed [OW-1:0] y0,
   output logic signed [OW-1:0] y1
);

   localparam int M  = NTAPS / 2;
   localparam int KW = CW + 1;
   localparam int AW = OW + 4;

   function automatic logic signed [CW-1:0] coef(input int i);
      return COEF_VEC[i*CW +: CW];
   endfunction

   // sel: 0 = phase sum, 1 = phase difference, 2 = odd phase alone
   function automatic logic [M*KW-1:0] sub_vec(input int sel);
      logic [M*KW-1:0]        v;
      logic signed [KW-1:0]   he, ho, e;
      v = '0;
      for (int k = 0; k < M; k++) begin
         he = KW'(coef(2*k));
         ho = KW'(coef(2*k+1));
         case (sel)
            0:       e = he + ho;
            1:       e = he - ho;
            default: e = ho;
         endcase
         v[k*KW +: KW] = e;
      end
      return v;
   endfunction

   localparam logic [M*KW-1:0] K_SUM = sub_vec(0);
   localparam logic [M*KW-1:0] K_DIF = sub_vec(1);
   localparam logic [M*KW-1:0] K_ODD = sub_vec(2);

   if ((NTAPS % 2) != 0 || NTAPS < 4) begin : g_len_bad
      $error("fsf_sym2_fir: NTAPS must be even and at least 4");
   end
   for (genvar i = 0; i < NTAPS/2; i++) begin : g_sym
      if (coef(i) != coef(NTAPS-1-i)) begin : g_bad
         $error("fsf_sym2_fir: coefficient set is not even-symmetric");
      end
   end
   if (OW < DW + CW + $clog2(NTAPS) - 1) begin : g_ow_bad
      $error("fsf_sym2_fir: OW too narrow for exact results");
   end

   // Pre-processing: sum and difference of the two phases
   logic signed [DW:0] s_in, d_in;
   assign s_in = (DW+1)'(x0) + (DW+1)'(x1);
   assign d_in = (DW+1)'(x0) - (DW+1)'(x1);

   logic signed [AW-1:0] a_sum, b_dif, c_odd;
   logic                 stage1_v;

   fsf_fold_branch #(
      .M(M), .IW(DW+1), .KW(KW), .AW(AW), .MODE(FOLD_SUM), .KVEC(K_SUM)
   ) i_sum_branch (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .din(s_in), .acc(a_sum)
   );

   fsf_fold_branch #(
      .M(M), .IW(DW+1), .KW(KW), .AW(AW), .MODE(FOLD_DIFF), .KVEC(K_DIF)
   ) i_dif_branch (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .din(d_in), .acc(b_dif)
   );

   fsf_plain_branch #(
      .M(M), .IW(DW), .KW(KW), .AW(AW), .KVEC(K_ODD)
   ) i_odd_branch (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .din(x1), .acc(c_odd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage1_v <= 1'b0;
      else        stage1_v <= in_valid;
   end

   fsf_recombine #(
      .AW(AW), .OW(OW)
   ) i_recombine (
      .clk(clk), .rst_n(rst_n), .en(stage1_v),
      .a_sum(a_sum), .b_dif(b_dif), .c_odd(c_odd),
      .out_valid(out_valid), .y0(y0), .y1(y1)
   );

endmodule

// File: rtl/fsf_sym2_fir_chk.sv
module fsf_sym2_fir_chk #(
   parameter int OW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic [OW-1:0] y0,
   input logic [OW-1:0] y1
);

   logic [1:0] age;
   logic       rst_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   always_ff @(posedge clk) rst_seen <= !rst_n;

   // R6
   always @(posedge clk) begin
      if (!rst_n && rst_seen) begin
         reset_state_chk: assert (!out_valid && y0 == '0 && y1 == '0)
            else $error("reset_state_chk: outputs not cleared in reset");
      end
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)))
      else $error("latency_chk: out_valid does not follow in_valid by two cycles");

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !out_valid) |-> ($stable(y0) && $stable(y1)))
      else $error("hold_chk: outputs changed without out_valid");

   // R1
   known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown({y0, y1}))
      else $error("known_chk: unknown output while valid");

endmodule

bind fsf_sym2_fir fsf_sym2_fir_chk #(.OW(OW)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .out_valid(out_valid), .y0(y0), .y1(y1)
);

// File: tb/test_fsf_sym2_fir.sv
module test_fsf_sym2_fir;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int CW = 12;
   localparam int NT = 10;
   localparam int OW = DW + CW + $clog2(NT);
   localparam int H [NT] = '{2, -7, -19, 54, 161, 161, 54, -19, -7, 2};

   function automatic logic [NT*CW-1:0] pack_coefs();
      logic [NT*CW-1:0] v;
      for (int i = 0; i < NT; i++) v[i*CW +: CW] = CW'(H[i]);
      return v;
   endfunction

   localparam logic [NT*CW-1:0] COEFS = pack_coefs();

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] x0 = '0;
   logic signed [DW-1:0] x1 = '0;
   logic                 out_valid;
   logic signed [OW-1:0] y0, y1;

   fsf_sym2_fir #(
      .DW(DW), .CW(CW), .NTAPS(NT), .COEF_VEC(COEFS), .OW(OW)
   ) i_fsf_sym2_fir (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0(x0), .x1(x1),
      .out_valid(out_valid), .y0(y0), .y1(y1)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int     cyc = 0;
   int     checks = 0;
   int     fails = 0;
   string  phase = "start";
   longint hist[$];
   longint q_y0[$];
   longint q_y1[$];
   int     q_cyc[$];
   logic   have_last = 1'b0;
   logic signed [OW-1:0] last_y0, last_y1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint ref_y(input int m);
      longint acc = 0;
      for (int i = 0; i < NT; i++)
         if (m - i >= 0) acc += longint'(H[i]) * hist[m-i];
      return acc;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
      end
   endtask

   task automatic send(input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      x0 = a;
      x1 = b;
      hist.push_back(longint'(a));
      hist.push_back(longint'(b));
      q_y0.push_back(ref_y(hist.size() - 2));
      q_y1.push_back(ref_y(hist.size() - 1));
      q_cyc.push_back(cyc);
   endtask

   // R4: idle cycles carry garbage that must not matter
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         x0 = DW'($urandom());
         x1 = DW'($urandom());
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      have_last = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 out_valid in reset", longint'(out_valid), 0);
      check("R6 y0 in reset", longint'(y0), 0);
      check("R6 y1 in reset", longint'(y1), 0);
      hist.delete();
      rst_n = 1'b1;
   endtask

   // Monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (out_valid === 1'b1) begin
            if (q_y0.size() == 0) begin
               check("R3 result without input", 1, 0);
            end else begin
               check("R1 y0", longint'(y0), q_y0.pop_front());
               check("R2 y1", longint'(y1), q_y1.pop_front());
               check("R3 arrival cycle", longint'(cyc), longint'(q_cyc.pop_front() + 2));
            end
            last_y0 = y0;
            last_y1 = y1;
            have_last = 1'b1;
         end else if (have_last) begin
            check("R5 y0 hold", longint'(y0), longint'(last_y0));
            check("R5 y1 hold", longint'(y1), longint'(last_y1));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      phase = "R6 initial reset";
      do_reset();
      idle(2);

      phase = "R1 R2 impulse on x0";
      send(16'sd1, 16'sd0);
      for (int i = 0; i < 6; i++) send(16'sd0, 16'sd0);
      idle(3);

      phase = "R1 R2 impulse on x1";
      send(16'sd0, 16'sd1);
      for (int i = 0; i < 6; i++) send(16'sd0, 16'sd0);
      idle(3);

      phase = "R1 R2 random";
      for (int i = 0; i < 40; i++) send(DW'($urandom()), DW'($urandom()));
      idle(3);

      phase = "R7 full scale";
      for (int i = 0; i < 12; i++) send(16'sd32767, 16'sd32767);
      for (int i = 0; i < 12; i++) send(-16'sd32768, -16'sd32768);
      for (int i = 0; i < 12; i++) send(16'sd32767, -16'sd32768);
      for (int i = 0; i < 12; i++) send(-16'sd32768, 16'sd32767);
      idle(3);

      phase = "R4 R5 gapped input";
      for (int i = 0; i < 40; i++) begin
         send(DW'($urandom()), DW'($urandom()));
         idle(int'($urandom_range(0, 3)));
      end
      idle(4);

      phase = "R6 mid-run reset";
      do_reset();
      for (int i = 0; i < 10; i++) send(DW'($urandom()), DW'($urandom()));
      idle(4);

      check("R3 scoreboard drained", longint'(q_y0.size()), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule